// File: doc/BRIEF.md
# Command/Reply Register Access Engine

This block sits behind a serial receiver that has already framed and validated incoming three-byte commands (operation code, data byte, checksum). For each command it handed in, the engine acts on a small internal register array. It reaches that array through one address pointer. It then sends a three-byte reply toward a UART transmitter, one byte at a time, over a valid/ready byte interface.

Three operations exist: load the pointer, write a register, and read a register. Reads and writes both move the pointer forward by one after the access. A host can therefore load the pointer once and then stream through consecutive registers.

Every reply starts with the received operation code with its top bit forced to 1. No valid command has that bit set, so a reply can never be taken for a command. The second reply byte is the data, and the third is a checksum of the first two. The engine accepts no new command until all three reply bytes have left.

Top module: `cmd_reg_engine`

## Requirements
- R1: After reset, `tx_valid` is 0, `cmd_ready` is 1, the pointer is 0 and every register holds 0.
- R2: Each accepted command produces exactly one reply of exactly three bytes, in this order: echo, data, checksum.
- R3: The echo byte equals the received code with bit 7 set to 1 (code | 0x80).
- R4: The checksum byte is (echo + data) modulo 256.
- R5: Code 0x01 loads the pointer with the command data modulo DEPTH. The reply data is the new pointer value.
- R6: Code 0x02 stores the command data at the pointer and then increments the pointer. The reply data is the stored value.
- R7: Code 0x03 returns the register at the pointer as reply data, leaves that register unchanged, and then increments the pointer.
- R8: An increment from register DEPTH-1 wraps the pointer to 0.
- R9: Any other code gets reply data 0xFF and changes neither the pointer nor any register.
- R10: `cmd_ready` is 0 from the cycle after a command is accepted until the third reply byte has been taken (`tx_valid` and `tx_ready` both 1).
- R11: While `tx_valid` is 1 and `tx_ready` is 0, the next cycle keeps `tx_valid` at 1 and `tx_byte` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A validated command is offered |
| cmd_ready | output | 1 | The engine can take a command |
| cmd_code | input | 8 | Operation code of the offered command |
| cmd_data | input | 8 | Data byte of the offered command |
| tx_valid | output | 1 | A reply byte is offered |
| tx_ready | input | 1 | The transmitter takes the offered byte |
| tx_byte | output | 8 | Current reply byte |

## Verification
The bench starts with reads straight after reset, which show the pointer and register reset values. It then writes an ascending run, loads the pointer again and reads the run back. This separates auto-increment from a fixed pointer, and a real store from an echo of the write data.

Further tests load the pointer to the last register and to a value above DEPTH, which exposes wrap and modulo errors. Unknown codes are placed between known reads, so any hidden pointer or register change shows in the following read data. Every pattern is run once with the transmitter always ready and again under pseudo-random back-pressure, which separates correct byte holding and command blocking from logic that only works without stalls.

// File: rtl/cre_pkg.sv
package cre_pkg;
   localparam logic [7:0] OP_SETPTR    = 8'h01;
   localparam logic [7:0] OP_WRITE     = 8'h02;
   localparam logic [7:0] OP_READ      = 8'h03;
   localparam logic [7:0] REPLY_MARK   = 8'h80;
   localparam logic [7:0] UNKNOWN_FILL = 8'hFF;

   typedef enum logic [1:0] {
      K_SETPTR,
      K_WRITE,
      K_READ,
      K_BAD
   } op_kind_t;

   typedef struct packed {
      logic [7:0] echo;
      logic [7:0] data;
      logic [7:0] sum;
   } reply_t;
endpackage

// File: rtl/cre_regfile.sv
module cre_regfile #(
   parameter int         DEPTH     = 16,
   parameter logic [7:0] RESET_VAL = 8'h00,
   localparam int        AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wr_data,
   output logic [7:0]    rd_data
);
   logic [7:0] regs [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs[i] <= RESET_VAL;
      end else if (wr_en) begin
         regs[addr] <= wr_data;
      end
   end

   assign rd_data = regs[addr];
endmodule

// File: rtl/cre_exec.sv
module cre_exec
   import cre_pkg::*;
#(
   parameter int  DEPTH = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam bit POW2  = (DEPTH == (1 << AW))
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [7:0]    code,
   input  logic [7:0]    data,
   input  logic [7:0]    rd_value,
   output logic          wr_en,
   output logic [AW-1:0] ptr,
   output reply_t        reply
);
   op_kind_t      kind;
   logic [AW-1:0] ptr_inc;
   logic [AW-1:0] ptr_load;
   logic [AW-1:0] ptr_next;
   logic [7:0]    rep_data;
   logic [7:0]    echo;

   always_comb begin
      unique case (code)
         OP_SETPTR: kind = K_SETPTR;
         OP_WRITE:  kind = K_WRITE;
         OP_READ:   kind = K_READ;
         default:   kind = K_BAD;
      endcase
   end

   generate
      if (POW2) begin : g_pow2
         assign ptr_inc  = ptr + 1'b1;
         assign ptr_load = data[AW-1:0];
      end else begin : g_mod
         assign ptr_inc  = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
         assign ptr_load = AW'(32'(data) % DEPTH);
      end
   endgenerate

   always_comb begin
      ptr_next = ptr;
      rep_data = UNKNOWN_FILL;
      unique case (kind)
         K_SETPTR: begin ptr_next = ptr_load; rep_data = 8'(ptr_load); end
         K_WRITE:  begin ptr_next = ptr_inc;  rep_data = data;         end
         K_READ:   begin ptr_next = ptr_inc;  rep_data = rd_value;     end
         default:  begin ptr_next = ptr;      rep_data = UNKNOWN_FILL; end
      endcase
   end

   assign echo       = code | REPLY_MARK;
   assign reply.echo = echo;
   assign reply.data = rep_data;
   assign reply.sum  = echo + rep_data;
   assign wr_en      = accept && (kind == K_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (accept) ptr <= ptr_next;
   end

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (code == OP_WRITE || code == OP_READ) && ptr == AW'(DEPTH - 1) |=> ptr == '0);
   assert_bad_keeps_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      accept && code != OP_SETPTR && code != OP_WRITE && code != OP_READ |=> $stable(ptr));
   assert_read_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept && code == OP_READ |-> !wr_en);
endmodule

// File: rtl/cre_reply_ser.sv
module cre_reply_ser
   import cre_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  reply_t     frame_in,
   output logic       idle,
   output logic       tx_valid,
   input  logic       tx_ready,
   output logic [7:0] tx_byte
);
   localparam int LAST = 2;

   reply_t     frame_q;
   logic [1:0] idx;
   logic       busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         idx     <= '0;
         busy    <= 1'b0;
      end else if (load) begin
         frame_q <= frame_in;
         idx     <= '0;
         busy    <= 1'b1;
      end else if (busy && tx_ready) begin
         if (idx == 2'(LAST)) busy <= 1'b0;
         else                 idx  <= idx + 1'b1;
      end
   end

   always_comb begin
      unique case (idx)
         2'd0:    tx_byte = frame_q.echo;
         2'd1:    tx_byte = frame_q.data;
         default: tx_byte = frame_q.sum;
      endcase
   end

   assign tx_valid = busy;
   assign idle     = !busy;

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
   assert_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && idx == 2'd0 |-> tx_byte[7]);
   assert_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && idx == 2'd2 |-> tx_byte == 8'(frame_q.echo + frame_q.data));
   assert_three_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && idx == 2'd2 |=> !tx_valid);
   assert_no_load_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);
endmodule

// File: rtl/cmd_reg_engine.sv
module cmd_reg_engine
   import cre_pkg::*;
#(
   parameter int         DEPTH     = 16,
   parameter logic [7:0] RESET_VAL = 8'h00,
   localparam int        AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [7:0] cmd_code,
   input  logic [7:0] cmd_data,
   output logic       tx_valid,
   input  logic       tx_ready,
   output logic [7:0] tx_byte
);
   generate
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("cmd_reg_engine: DEPTH must lie in 2..256");
      end
   endgenerate

   logic          accept;
   logic          wr_en;
   logic [AW-1:0] ptr;
   logic [7:0]    rd_value;
   reply_t        reply;

   assign accept = cmd_valid && cmd_ready;

   cre_regfile #(.DEPTH(DEPTH), .RESET_VAL(RESET_VAL)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (ptr),
      .wr_data (cmd_data),
      .rd_data (rd_value)
   );

   cre_exec #(.DEPTH(DEPTH)) u_exec (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .code     (cmd_code),
      .data     (cmd_data),
      .rd_value (rd_value),
      .wr_en    (wr_en),
      .ptr      (ptr),
      .reply    (reply)
   );

   cre_reply_ser u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .frame_in (reply),
      .idle     (cmd_ready),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .tx_byte  (tx_byte)
   );

   assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !cmd_ready);
   assert_accept_starts_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> tx_valid);
endmodule

// File: tb/cmd_reg_engine_test.sv
module cmd_reg_engine_test;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [7:0] cmd_code = '0;
   logic [7:0] cmd_data = '0;
   logic       tx_valid;
   logic       tx_ready = 1'b1;
   logic [7:0] tx_byte;

   int checks = 0;
   int errors = 0;
   int n_cmds = 0;
   int n_bytes = 0;
   int rdy_mode = 0;
   logic [7:0] lfsr = 8'hA5;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   logic [7:0] model_mem [DEPTH];
   int         model_ptr = 0;

   logic       prev_stall = 1'b0;
   logic [7:0] prev_byte = '0;

   always #5 clk = ~clk;

   cmd_reg_engine #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_code(cmd_code), .cmd_data(cmd_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_byte(tx_byte)
   );

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // driver: computes the expected reply from the requirements and queues it
   task automatic send(input logic [7:0] code, input logic [7:0] data, input string tag);
      logic [7:0] echo;
      logic [7:0] rdata;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = code;
      cmd_data  = data;
      echo = code | 8'h80;                                  // R3
      case (code)
         8'h01: begin model_ptr = data % DEPTH; rdata = 8'(model_ptr); end   // R5
         8'h02: begin model_mem[model_ptr] = data; rdata = data;             // R6
                      model_ptr = (model_ptr + 1) % DEPTH; end                // R8
         8'h03: begin rdata = model_mem[model_ptr];                          // R7
                      model_ptr = (model_ptr + 1) % DEPTH; end
         default: rdata = 8'hFF;                                              // R9
      endcase
      exp_q.push_back(echo);          tag_q.push_back("R3 echo");
      exp_q.push_back(rdata);         tag_q.push_back(tag);
      exp_q.push_back(echo + rdata);  tag_q.push_back("R4 checksum");
      n_cmds++;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // monitor: back-pressure pattern, hold checks, scoreboard compare
   always @(negedge clk) begin
      if (rst_n) begin
         if (rdy_mode == 0) tx_ready = 1'b1;
         else begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tx_ready = lfsr[0] | lfsr[2];
         end
         if (prev_stall) begin
            check(tx_valid == 1'b1, "R11 valid held", {7'd0, tx_valid}, 8'd1);
            check(tx_byte == prev_byte, "R11 byte held", tx_byte, prev_byte);
         end
         if (tx_valid) check(cmd_ready == 1'b0, "R10 ready low while replying", {7'd0, cmd_ready}, 8'd0);
         if (tx_valid && tx_ready) begin
            n_bytes++;
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", tx_byte, 8'h00);
            else begin
               automatic logic [7:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               check(tx_byte == e, t, tx_byte, e);
            end
         end
         prev_stall = tx_valid && !tx_ready;
         prev_byte  = tx_byte;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 8'h00, 8'h00);
      summary();
   end

   task automatic pattern_set();
      // R1: reset contents read through the normal interface
      send(8'h03, 8'h00, "R1 R7 read reg0 after reset");
      send(8'h03, 8'h00, "R1 R7 read reg1 after reset");
      send(8'h01, 8'h05, "R5 set pointer");
      for (int i = 0; i < 4; i++) send(8'h02, 8'(8'h30 + 16 * i + rdy_mode), "R6 write echo");
      send(8'h01, 8'h05, "R5 set pointer");
      for (int i = 0; i < 4; i++) send(8'h03, 8'h00, "R7 read back");
      send(8'h01, 8'hF3, "R5 pointer modulo DEPTH");
      send(8'h02, 8'h77, "R6 write at 3");
      send(8'h01, 8'h0F, "R5 set last");
      send(8'h02, 8'hE1, "R6 write last");
      send(8'h02, 8'hE2, "R8 write after wrap");
      send(8'h01, 8'h0F, "R5 set last");
      send(8'h03, 8'h00, "R7 read last");
      send(8'h03, 8'h00, "R8 read after wrap");
      send(8'h44, 8'h12, "R9 unknown code");
      send(8'h00, 8'h99, "R9 code zero");
      send(8'h81, 8'h02, "R9 marked code");
      send(8'h03, 8'h00, "R9 pointer unchanged");
      send(8'h01, 8'h03, "R5 set pointer");
      send(8'h03, 8'h00, "R6 R9 reg3 intact");
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      check(tx_valid == 1'b0, "R1 tx_valid in reset", {7'd0, tx_valid}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_valid == 1'b0, "R1 tx_valid after reset", {7'd0, tx_valid}, 8'd0);
      check(cmd_ready == 1'b1, "R1 cmd_ready after reset", {7'd0, cmd_ready}, 8'd1);
      rdy_mode = 0;
      pattern_set();
      rdy_mode = 1;
      pattern_set();
      while (exp_q.size() != 0 || tx_valid) @(negedge clk);
      repeat (2) @(negedge clk);
      check(n_bytes == 3 * n_cmds, "R2 three bytes per command", 8'(n_bytes), 8'(3 * n_cmds));
      check(cmd_ready == 1'b1, "R10 ready after last byte", {7'd0, cmd_ready}, 8'd1);
      summary();
   end
endmodule